// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is the master side of a two-wire serial management bus. It reads and writes 16-bit registers in Ethernet PHYs. A host issues a one-cycle start pulse together with a direction flag, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. The master then produces the management clock and sends the frame out. On a read it releases the data line and captures the PHY's reply. When it finishes, it returns the read word, an error flag and a one-cycle completion pulse.

The management clock rate is set at run time by a half-period count in system clocks, and the block latches that count when a transaction is accepted.

Before it accepts read data, the master checks that the PHY pulled the first turnaround bit low. If the PHY left the line high, the master keeps the line released for a recovery burst of clocks and reports an error instead of data. Every frame begins with a full preamble. A read ends with one and a half extra clock cycles, so the management clock settles low.

Top module: `mdio_master`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `mdc_o` and `mdio_oe` are 0 and `rdata` is 0. Whenever no transaction is in progress, `mdc_o` and `mdio_oe` are 0.
- R2: Every frame opens with 32 management clock cycles. In each of them `mdio_oe` is 1 and `mdio_o` is 1 at the rising edge of `mdc_o`.
- R3: Cycles 32 to 45, counted from 0 by rising edge of `mdc_o`, carry the following 14 bits, all driven:
  - the start pattern 0, 1;
  - the opcode, which is 1, 0 for a read (`rd_nwr`=1) and 0, 1 for a write;
  - the PHY address, most significant bit first;
  - the register address, most significant bit first.
- R4: `mdio_o` changes only while `mdc_o` is low. Every half-period of `mdc_o` within a frame lasts `half_div` system clocks, or 1 clock when `half_div` is 0.
- R5: On a write, cycles 46 and 47 drive 1 then 0. Cycles 48 to 63 drive the 16 data bits, most significant first. Cycle 64 has `mdio_oe`=0. A write produces exactly 65 rising edges of `mdc_o`.
- R6: On a read, `mdio_oe` is 0 from cycle 46 to the end of the frame. `mdio_i` passes through a two-flop synchronizer and is sampled at the end of each high half-period. When the turnaround bit (cycle 46) samples 0, the bits of cycles 47 to 62 form `rdata`, most significant first, and `err` is 0. A good read produces 64 rising edges and ends on a low half-period. Correct capture requires `half_div` ≥ 2 with the PHY changing the line just after the falling edge of `mdc_o`.
- R7: If the turnaround bit samples 1, the master gives 32 further cycles with `mdio_oe`=0, 79 rising edges in all. It then completes with `err`=1 and `rdata`=0.
- R8: `start` is accepted only when idle. A `start` while `busy` has no effect on the frame. `busy` is 1 from the cycle after an accepted start until the cycle of `done`, and `done` pulses exactly once per transaction.
- R9: `rdata` and `err` hold their values from completion until the next accepted start. A good transaction after a failed one clears `err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle transaction request |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Write data |
| half_div | input | DIV_W | Management clock half-period in system clocks (0 acts as 1) |
| rdata | output | 16 | Read result |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Turnaround check failed on the last read |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
A PHY responder in the bench records every bit at each rising edge of `mdc_o`. It replies on falling edges and applies random register values. The stimulus is random reads and writes over all addresses and data values, with half-periods from 1 to 5. Directed cases cover the following, and each separates a different fault:
- all-zero and all-one data with extreme addresses, which catches shift-order and opcode errors;
- a half-period of 0, which tests the clamp to one clock;
- a PHY that never drives turnaround, which catches a wrong recovery length, wrong error flag or leftover data;
- a start pulse during a busy frame, which catches a restart or a field corruption.

Edge counts and half-period lengths separate the three frame endings.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int RECOV_LEN = 32;
    localparam int FRAME_W   = 32;
    localparam int HDR_BITS  = 4 + 2 * ADDR_W;
    localparam int CNT_W     = $clog2(FRAME_W) + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SEND,
        ST_TA_CHK,
        ST_RD_DATA,
        ST_TAIL,
        ST_TAIL_LOW,
        ST_RECOVER
    } mst_state_e;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mreq_t;

    // Outgoing bits after the preamble, first bit in the MSB.
    function automatic logic [FRAME_W-1:0] build_frame(mreq_t r);
        logic [1:0] op;
        op = r.rd ? 2'b10 : 2'b01;
        if (r.rd)
            return {2'b01, op, r.phy, r.regad, {(FRAME_W-HDR_BITS){1'b0}}};
        else
            return {2'b01, op, r.phy, r.regad, 2'b10, r.wdata};
    endfunction

endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

    initial begin
        a_r6_sync_depth: assert (STAGES >= 2)
            else $error("synchronizer needs at least two stages");
    end
endmodule

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] hp_eff;

    assign hp_eff = (half_div == '0) ? DIV_W'(1) : half_div;
    assign tick   = run && (cnt == hp_eff - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + DIV_W'(1);
    end

    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < hp_eff));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                rd_nwr,
    input  logic [ADDR_W-1:0]   phy_addr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DIV_W-1:0]    half_div,
    output logic [DATA_W-1:0]   rdata,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic                mdc_o,
    output logic                mdio_o,
    output logic                mdio_oe,
    input  logic                mdio_i
);
    localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_LEN - 1);
    localparam logic [CNT_W-1:0] RECOV_LAST = CNT_W'(RECOV_LEN - 1);
    localparam logic [CNT_W-1:0] RD_LAST    = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] WR_LAST    = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(DATA_W - 1);

    mst_state_e          st;
    mreq_t               req_q;
    logic [DIV_W-1:0]    hp_q;
    logic [FRAME_W-1:0]  sh;
    logic [CNT_W-1:0]    cnt;
    logic [DATA_W-1:0]   rsh;
    logic [DATA_W-1:0]   rdata_q;
    logic                mdc_q, mdo_q, oe_q, done_q, err_q;
    logic                tick, s_in, end_cyc, end_low;
    mreq_t               req_in;

    assign req_in = '{rd: rd_nwr, phy: phy_addr, regad: reg_addr, wdata: wdata};

    mdio_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .run(st != ST_IDLE), .half_div(hp_q), .tick(tick)
    );

    mdio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(mdio_i), .q(s_in)
    );

    assign end_cyc = tick &&  mdc_q;
    assign end_low = tick && !mdc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            req_q   <= '0;
            hp_q    <= '0;
            sh      <= '0;
            cnt     <= '0;
            rsh     <= '0;
            rdata_q <= '0;
            mdc_q   <= 1'b0;
            mdo_q   <= 1'b1;
            oe_q    <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (st == ST_IDLE) begin
                if (start) begin
                    st      <= ST_PRE;
                    req_q   <= req_in;
                    hp_q    <= half_div;
                    sh      <= build_frame(req_in);
                    cnt     <= '0;
                    mdc_q   <= 1'b0;
                    mdo_q   <= 1'b1;
                    oe_q    <= 1'b1;
                    err_q   <= 1'b0;
                    rdata_q <= '0;
                end
            end else if (st == ST_TAIL_LOW) begin
                if (end_low) begin
                    st     <= ST_IDLE;
                    done_q <= 1'b1;
                end
            end else begin
                if (tick) mdc_q <= !mdc_q;
                if (end_cyc) begin
                    unique case (st)
                        ST_PRE: begin
                            if (cnt == PRE_LAST) begin
                                st    <= ST_SEND;
                                cnt   <= '0;
                                mdo_q <= sh[FRAME_W-1];
                                sh    <= sh << 1;
                            end else cnt <= cnt + 1'b1;
                        end
                        ST_SEND: begin
                            if (cnt == (req_q.rd ? RD_LAST : WR_LAST)) begin
                                st    <= req_q.rd ? ST_TA_CHK : ST_TAIL;
                                cnt   <= '0;
                                oe_q  <= 1'b0;
                                mdo_q <= 1'b1;
                            end else begin
                                cnt   <= cnt + 1'b1;
                                mdo_q <= sh[FRAME_W-1];
                                sh    <= sh << 1;
                            end
                        end
                        ST_TA_CHK: begin
                            st  <= s_in ? ST_RECOVER : ST_RD_DATA;
                            cnt <= '0;
                        end
                        ST_RD_DATA: begin
                            rsh <= {rsh[DATA_W-2:0], s_in};
                            if (cnt == DATA_LAST) begin
                                st      <= ST_TAIL;
                                rdata_q <= {rsh[DATA_W-2:0], s_in};
                            end else cnt <= cnt + 1'b1;
                        end
                        ST_TAIL: begin
                            if (req_q.rd) st <= ST_TAIL_LOW;
                            else begin
                                st     <= ST_IDLE;
                                done_q <= 1'b1;
                            end
                        end
                        ST_RECOVER: begin
                            if (cnt == RECOV_LAST) begin
                                st      <= ST_IDLE;
                                done_q  <= 1'b1;
                                err_q   <= 1'b1;
                                rdata_q <= '0;
                            end else cnt <= cnt + 1'b1;
                        end
                        default: st <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    assign busy    = (st != ST_IDLE);
    assign done    = done_q;
    assign err     = err_q;
    assign rdata   = rdata_q;
    assign mdc_o   = mdc_q;
    assign mdio_o  = mdo_q;
    assign mdio_oe = oe_q;

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r8_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(req_q));
    a_r4_change_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_o) |-> !mdc_o);
    a_r6_released: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TA_CHK || st == ST_RD_DATA || st == ST_RECOVER) |-> !mdio_oe);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc_o && !mdio_oe));
    a_r7_err_at_done: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done);
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(rdata) && $stable(err)));
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    localparam int DIV_W = 8;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, rd_nwr = 1'b0;
    logic [4:0] phy_addr = '0, reg_addr = '0;
    logic [15:0] wdata = '0;
    logic [DIV_W-1:0] half_div = 8'd2;
    logic [15:0] rdata;
    logic busy, done, err, mdc_o, mdio_o, mdio_oe, mdio_i;

    always #5 clk = ~clk;

    // PHY responder state
    logic phy_val = 1'b1;
    bit   ta_fail_mode = 0;
    logic [15:0] phy_reg = '0;
    assign mdio_i = mdio_oe ? mdio_o : phy_val;

    mdio_master #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst(rst), .start(start), .rd_nwr(rd_nwr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
        .half_div(half_div), .rdata(rdata), .busy(busy), .done(done),
        .err(err), .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    int n_tests = 0, n_fail = 0;
    int cyc = 0, rises = 0, done_cnt = 0, last_tr = 0, hp_exp = 1;
    bit have_tr = 0, bad_iv = 0, bad_chg = 0, mon_en = 0;
    logic prev_mdc = 1'b0, prev_mdo = 1'b1;
    logic rec_d [0:127];
    logic rec_oe[0:127];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic phy_bit(input int c);
        if (ta_fail_mode) return 1'b1;
        if (c == 46) return 1'b0;
        if (c >= 47 && c <= 62) return phy_reg[15-(c-47)];
        return 1'b1;
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (mon_en) begin
            if (done) done_cnt++;
            if (mdc_o != prev_mdc) begin
                if (have_tr && (cyc - last_tr) != hp_exp) bad_iv = 1;
                have_tr = 1;
                last_tr = cyc;
                if (mdc_o) begin
                    if (rises < 128) begin
                        rec_d[rises]  = mdio_o;
                        rec_oe[rises] = mdio_oe;
                    end
                    rises++;
                end else begin
                    phy_val = phy_bit(rises);
                end
            end
            if (mdio_o != prev_mdo && mdc_o && prev_mdc) bad_chg = 1;
        end
        prev_mdc = mdc_o;
        prev_mdo = mdio_o;
        if (cyc > WATCHDOG) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=<%0d", cyc, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic run_txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input int hp, input bit ta_bad,
                           input logic [15:0] preg, input bit poke_busy);
        logic [13:0] hdr;
        logic [17:0] wtail;
        int bad, tmo;
        logic [15:0] hold_rd;
        logic hold_err;
        @(negedge clk);
        rises = 0; done_cnt = 0; have_tr = 0; bad_iv = 0; bad_chg = 0;
        phy_val = 1'b1; ta_fail_mode = ta_bad; phy_reg = preg;
        hp_exp = (hp == 0) ? 1 : hp;
        mon_en = 1;
        rd_nwr = rd; phy_addr = pa; reg_addr = ra; wdata = wd; half_div = DIV_W'(hp);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8 busy after start", busy, 1);
        if (poke_busy) begin
            repeat (40) @(negedge clk);
            rd_nwr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        tmo = 0;
        while (!done && tmo < 5000) begin
            @(negedge clk);
            tmo++;
        end
        chk(tmo < 5000, "R8 done reached", tmo, 5000);
        repeat (2) @(negedge clk);
        mon_en = 0;

        bad = 0;
        for (int c = 0; c < 32; c++) if (rec_d[c] !== 1'b1 || rec_oe[c] !== 1'b1) bad++;
        chk(bad == 0, "R2 preamble", bad, 0);
        hdr = {2'b01, (rd ? 2'b10 : 2'b01), pa, ra};
        bad = 0;
        for (int c = 32; c < 46; c++) if (rec_d[c] !== hdr[13-(c-32)] || rec_oe[c] !== 1'b1) bad++;
        chk(bad == 0, "R3 header", bad, 0);
        chk(!bad_iv, "R4 half-period length", bad_iv, 0);
        chk(!bad_chg, "R4 change while high", bad_chg, 0);
        chk(done_cnt == 1, "R8 one done pulse", done_cnt, 1);
        chk(!busy && !mdc_o && !mdio_oe, "R1 idle after frame", {busy, mdc_o, mdio_oe}, 0);

        if (!rd) begin
            wtail = {2'b10, wd};
            bad = 0;
            for (int c = 46; c < 64; c++) if (rec_d[c] !== wtail[17-(c-46)] || rec_oe[c] !== 1'b1) bad++;
            chk(bad == 0, "R5 turnaround and data", bad, 0);
            chk(rec_oe[64] === 1'b0, "R5 released last cycle", rec_oe[64], 0);
            chk(rises == 65, "R5 edge count", rises, 65);
        end else if (!ta_bad) begin
            bad = 0;
            for (int c = 46; c < 64; c++) if (rec_oe[c] !== 1'b0) bad++;
            chk(bad == 0, "R6 line released", bad, 0);
            chk(rises == 64, "R6 edge count", rises, 64);
            chk(rdata == preg, "R6 read data", rdata, preg);
            chk(err == 1'b0, "R6 no error", err, 0);
        end else begin
            bad = 0;
            for (int c = 46; c < 79; c++) if (rec_oe[c] !== 1'b0) bad++;
            chk(bad == 0, "R7 released in recovery", bad, 0);
            chk(rises == 79, "R7 edge count", rises, 79);
            chk(err == 1'b1, "R7 error flag", err, 1);
            chk(rdata == 16'h0, "R7 no data", rdata, 0);
        end

        hold_rd = rdata;
        hold_err = err;
        repeat (20) @(negedge clk);
        chk(rdata == hold_rd && err == hold_err, "R9 result held", {err, rdata}, {hold_err, hold_rd});
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !err && !mdc_o && !mdio_oe && rdata == 0,
            "R1 reset state", {busy, done, err, mdc_o, mdio_oe}, 0);

        // directed corner cases
        run_txn(1'b0, 5'd31, 5'd0, 16'hFFFF, 2, 0, 16'h0, 0);
        run_txn(1'b0, 5'd0, 5'd31, 16'h0000, 0, 0, 16'h0, 0);
        run_txn(1'b1, 5'd31, 5'd31, 16'h0, 2, 0, 16'hFFFF, 0);
        run_txn(1'b1, 5'd0, 5'd0, 16'h0, 3, 0, 16'h0000, 0);
        run_txn(1'b1, 5'd5, 5'd9, 16'h0, 2, 1, 16'hA5A5, 0);
        run_txn(1'b1, 5'd12, 5'd3, 16'h0, 2, 0, 16'h8001, 0);
        run_txn(1'b0, 5'd10, 5'd21, 16'h1357, 3, 0, 16'h0, 1);
        run_txn(1'b1, 5'd17, 5'd6, 16'h0, 4, 0, 16'h2468, 1);

        // random mix
        for (int i = 0; i < 30; i++) begin
            bit rd;
            int hp;
            rd = 1'($urandom % 2);
            hp = rd ? 2 + int'($urandom % 4) : 1 + int'($urandom % 5);
            run_txn(rd, 5'($urandom), 5'($urandom), 16'($urandom), hp,
                    rd && ($urandom % 6 == 0), 16'($urandom), 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule